// File: doc/BRIEF.md
# Interrupt Register Group Bank

This block holds one second-level interrupt group: four 32-bit registers that a register bus reaches at fixed word offsets from a configurable group base. A 32-bit event input carries one single-cycle pulse per source bit. An event is captured into the identity register only when its mask bit is clear. Software acknowledges a captured event by writing a one to that identity bit.

The block drives a 32-bit pending vector to an upstream aggregator. Each pending bit is the identity bit qualified by the matching enable bit. The mask decides whether an event is recorded at all. The enable decides only whether a recorded bit is forwarded. A status register shows the raw event pulses from the previous cycle for diagnostic reads.

Top module: `irq_group_bank`

## Requirements
- R1: While the synchronous active-low reset is asserted, every register and the pending output go to zero.
- R2: The registers decode at these byte offsets from BASE_ADDR: status +0x0, mask +0x4, identity +0x8, enable +0xC. Any other address reads as zero, and a write to it changes no register.
- R3: An event pulse on bit n with mask bit n equal to 0 sets identity bit n at the next clock edge. Bits without an event keep their value.
- R4: An event pulse on bit n with mask bit n equal to 1 is dropped. Clearing the mask afterwards does not set identity bit n.
- R5: A write to the identity register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: A write to the mask register or the enable register replaces all 32 bits with the written data.
- R7: pending_out equals identity AND enable. It follows any change of either register in the cycle after the write or event edge.
- R8: If an unmasked event on bit n and a write of 1 to identity bit n occur in the same cycle, identity bit n stays set.
- R9: Reading the identity register does not change it.
- R10: The status register is read-only. It returns the event input sampled at the previous clock edge, and writes to it are ignored.
- R11: An identity bit stays set after its event pulse ends, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr; combinational |
| evt_in | input | DATA_W | Event pulses, one bit per source |
| pending_out | output | DATA_W | Identity AND enable, sent to the aggregator |

## Verification
The properties assume that evt_in and the bus are quiet during reset. They check only cycles whose previous cycle was already out of reset, so a pulse during reset cannot look like a missed capture. They also assume that BASE_ADDR is aligned to 16 bytes, so all four registers share one upper address field. The bench holds every input at zero while reset is asserted. It changes inputs only on the falling clock edge, keeps each write strobe to one cycle, and uses a base of 0x040.

// File: rtl/irq_group_pkg.sv
// Shared definitions for the interrupt register group.
// Assumes 32-bit-aligned word registers within a 16-byte group window.
package irq_group_pkg;
    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_MASK   = 4'h4;
    localparam logic [3:0] OFF_IDENT  = 4'h8;
    localparam logic [3:0] OFF_ENABLE = 4'hC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_IDENT,
        SEL_ENABLE
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
// Maps a bus byte address to one of the group's four registers.
// Assumes BASE_ADDR is 16-byte aligned; misaligned or foreign addresses give SEL_NONE.
module irq_addr_decode
    import irq_group_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

    logic in_group;

    // Group hit: upper bits match the base.
    assign in_group = (addr[ADDR_W-1:4] == BASE_V[ADDR_W-1:4]);

    // Offset select within the 16-byte window.
    always_comb begin
        sel = SEL_NONE;
        if (in_group) begin
            case (addr[3:0])
                OFF_STATUS: sel = SEL_STATUS;
                OFF_MASK:   sel = SEL_MASK;
                OFF_IDENT:  sel = SEL_IDENT;
                OFF_ENABLE: sel = SEL_ENABLE;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_word_reg.sv
// Plain full-word register with a load strobe.
// Assumes the load data is stable at the clock edge; reset value is zero.
module irq_word_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load or clear the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/irq_ident_reg.sv
// Identity register: captures unmasked events and clears bits written as one.
// Assumes single-cycle event pulses. A capture beats a clear on the same bit.
module irq_ident_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    output logic [W-1:0] ident
);
    logic [W-1:0] ident_nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic capture;
        logic clear;
        // Per-bit next state: capture first, then clear, else hold.
        assign capture      = evt[i] & ~mask[i];
        assign clear        = clr_we & clr_data[i];
        assign ident_nxt[i] = capture ? 1'b1 : (clear ? 1'b0 : ident[i]);
    end

    // Commit the per-bit next state.
    always_ff @(posedge clk) begin
        if (!rst_n) ident <= '0;
        else        ident <= ident_nxt;
    end
endmodule

// File: rtl/irq_group_bank.sv
// One interrupt group: status, mask, identity and enable registers on a register bus.
// Assumes one-cycle write strobes and a 16-byte-aligned BASE_ADDR.
module irq_group_bank
    import irq_group_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_in,
    output logic [DATA_W-1:0] pending_out
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] ident_q;
    logic [DATA_W-1:0] enable_q;

    irq_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    irq_word_reg #(.W(DATA_W)) u_status (
        .clk (clk), .rst_n (rst_n), .load (1'b1), .d (evt_in), .q (status_q)
    );

    irq_word_reg #(.W(DATA_W)) u_mask (
        .clk (clk), .rst_n (rst_n), .load (bus_wr && sel == SEL_MASK),
        .d (bus_wdata), .q (mask_q)
    );

    irq_word_reg #(.W(DATA_W)) u_enable (
        .clk (clk), .rst_n (rst_n), .load (bus_wr && sel == SEL_ENABLE),
        .d (bus_wdata), .q (enable_q)
    );

    irq_ident_reg #(.W(DATA_W)) u_ident (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (bus_wr && sel == SEL_IDENT),
        .clr_data (bus_wdata),
        .evt      (evt_in),
        .mask     (mask_q),
        .ident    (ident_q)
    );

    // Forward latched bits qualified by the enable.
    assign pending_out = ident_q & enable_q;

    // Side-effect-free read mux.
    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata = status_q;
            SEL_MASK:   bus_rdata = mask_q;
            SEL_IDENT:  bus_rdata = ident_q;
            SEL_ENABLE: bus_rdata = enable_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_group_bank_chk.sv
// Property checker for irq_group_bank, attached by bind.
// Assumes quiet inputs during reset and a 16-byte-aligned base.
module irq_group_bank_chk #(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] evt_in,
    input logic [DATA_W-1:0] pending_out,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] ident_q,
    input logic [DATA_W-1:0] enable_q
);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(BASE_ADDR + 4);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(BASE_ADDR + 8);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(BASE_ADDR + 12);

    logic [DATA_W-1:0] unmasked_evt;
    assign unmasked_evt = evt_in & ~mask_q;

    // R3 and R8: every unmasked event bit is set one cycle later.
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ident_q & $past(unmasked_evt)) == $past(unmasked_evt)));

    // R4: an identity bit rises only with an unmasked event.
    a_r4_no_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ident_q & ~$past(ident_q) & ~$past(unmasked_evt)) == '0));

    // R5: bits written as one without a colliding event are cleared.
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IDENT) |=> ((ident_q & $past(bus_wdata & ~unmasked_evt)) == '0));

    // R6: a mask write replaces the whole word.
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata)));

    // R6: an enable write replaces the whole word.
    a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN) |=> (enable_q == $past(bus_wdata)));

    // R7: nothing is forwarded without both identity and enable.
    a_r7_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_out & ~(ident_q & enable_q)) == '0));
endmodule

bind irq_group_bank irq_group_bank_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .evt_in      (evt_in),
    .pending_out (pending_out),
    .mask_q      (mask_q),
    .ident_q     (ident_q),
    .enable_q    (enable_q)
);

// File: tb/sim_irq_group_bank.sv
`timescale 1ns/1ps
module sim_irq_group_bank;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] BASE = 12'h040;
    localparam logic [AW-1:0] A_ST = BASE + 12'h0;
    localparam logic [AW-1:0] A_MK = BASE + 12'h4;
    localparam logic [AW-1:0] A_ID = BASE + 12'h8;
    localparam logic [AW-1:0] A_EN = BASE + 12'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] evt_in = '0;
    logic [DW-1:0] pending_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_group_bank #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(32'h40)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .pending_out(pending_out)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [DW-1:0] e);
        @(negedge clk);
        evt_in = e;
        @(posedge clk); #1;
        evt_in = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clean();
        wr(A_MK, '0); wr(A_EN, '0); wr(A_ID, '1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(A_ST, v); check("R1 status", v, '0);
        rd(A_MK, v); check("R1 mask", v, '0);
        rd(A_ID, v); check("R1 identity", v, '0);
        rd(A_EN, v); check("R1 enable", v, '0);
        check("R1 pending", pending_out, '0);
    endtask

    task automatic t_decode();
        logic [DW-1:0] v;
        wr(A_MK, 32'h1234_5678); rd(A_MK, v); check("R2 mask at +4", v, 32'h1234_5678);
        wr(A_EN, 32'h0F0F_0000); rd(A_EN, v); check("R2 enable at +C", v, 32'h0F0F_0000);
        wr(BASE + 12'h10, 32'hFFFF_FFFF); rd(BASE + 12'h10, v); check("R2 outside reads 0", v, '0);
        wr(BASE + 12'h5, 32'hFFFF_FFFF); rd(A_MK, v); check("R2 misaligned write ignored", v, 32'h1234_5678);
        rd(A_EN, v); check("R2 enable untouched", v, 32'h0F0F_0000);
        clean();
    endtask

    task automatic t_latch();
        logic [DW-1:0] v;
        pulse(32'h0000_0011); rd(A_ID, v); check("R3 capture", v, 32'h0000_0011);
        pulse(32'h8000_0000); rd(A_ID, v); check("R3 accumulate", v, 32'h8000_0011);
        clean();
    endtask

    task automatic t_masked();
        logic [DW-1:0] v;
        wr(A_MK, 32'h0000_00F0);
        pulse(32'h0000_0030); rd(A_ID, v); check("R4 masked dropped", v, 32'h0000_0000);
        wr(A_MK, 32'h0); rd(A_ID, v); check("R4 not remembered after unmask", v, 32'h0);
        pulse(32'h0000_0101); rd(A_ID, v); check("R4 unmasked part captured", v, 32'h0000_0101);
        clean();
    endtask

    task automatic t_w1c();
        logic [DW-1:0] v;
        pulse(32'h0000_F00F);
        wr(A_ID, 32'h0000_1001); rd(A_ID, v); check("R5 w1c partial", v, 32'h0000_E00E);
        wr(A_ID, 32'h0); rd(A_ID, v); check("R5 zero write no change", v, 32'h0000_E00E);
        clean();
    endtask

    task automatic t_replace();
        logic [DW-1:0] v;
        wr(A_MK, 32'hFFFF_0000); wr(A_MK, 32'h0000_00FF); rd(A_MK, v); check("R6 mask replace", v, 32'h0000_00FF);
        wr(A_EN, 32'hAAAA_AAAA); wr(A_EN, 32'h5555_0000); rd(A_EN, v); check("R6 enable replace", v, 32'h5555_0000);
        clean();
    endtask

    task automatic t_pending();
        pulse(32'h0000_00FF);
        @(negedge clk); check("R7 enable zero", pending_out, '0);
        wr(A_EN, 32'h0000_000F);
        @(negedge clk); check("R7 enable write", pending_out, 32'h0000_000F);
        wr(A_ID, 32'h0000_0003);
        @(negedge clk); check("R7 after clear", pending_out, 32'h0000_000C);
        wr(A_MK, 32'hFFFF_FFFF);
        @(negedge clk); check("R7 mask keeps latched", pending_out, 32'h0000_000C);
        clean();
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        pulse(32'h0000_0006);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_ID; bus_wdata = 32'h0000_0006; evt_in = 32'h0000_0002;
        @(posedge clk); #1;
        bus_wr = 1'b0; evt_in = '0;
        rd(A_ID, v); check("R8 event beats clear", v, 32'h0000_0002);
        clean();
    endtask

    task automatic t_read_noside();
        logic [DW-1:0] v;
        pulse(32'h0001_0000);
        rd(A_ID, v); rd(A_ID, v); rd(A_ID, v); check("R9 repeated read", v, 32'h0001_0000);
        clean();
    endtask

    task automatic t_status();
        logic [DW-1:0] v;
        pulse(32'h00C0_0000); rd(A_ST, v); check("R10 status shows pulse", v, 32'h00C0_0000);
        rd(A_ST, v); check("R10 status follows input", v, '0);
        wr(A_ST, 32'hFFFF_FFFF); rd(A_ST, v); check("R10 status write ignored", v, '0);
        clean();
    endtask

    task automatic t_sticky();
        logic [DW-1:0] v;
        pulse(32'h0000_0400);
        repeat (5) @(posedge clk);
        rd(A_ID, v); check("R11 bit persists", v, 32'h0000_0400);
        clean();
        rd(A_ID, v); check("R11 clears on write", v, '0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_decode();
        t_latch();
        t_masked();
        t_w1c();
        t_replace();
        t_pending();
        t_collision();
        t_read_noside();
        t_status();
        t_sticky();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule